// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital control section of a 100-position digitally controlled potentiometer. It has three control wires: an active-low select, a direction input and a step strobe. Each high-to-low transition of the step strobe moves a 7-bit wiper position one tap, but only while the block is selected. The direction level at that edge decides whether the wiper moves up or down. The position stops at both ends of the range and never wraps. The position is decoded into a one-hot select vector with one line for each tap, and that vector drives the wiper switches of the resistor ladder. The ladder itself lies outside this block.

The block keeps a model nonvolatile cell. The current position is written into it when the select input is released while the step strobe is high. The power-up reset `rst_n` does not disturb this cell. When `rst_n` is released, the counter reloads the saved position from the cell. A separate input, `nv_rst_n`, blanks the cell to position 0, which models a part that has never been programmed.

All three control wires are treated as asynchronous. Each one passes through a two-stage synchronizer, and the block detects edges against the system clock. The power-up reset is asserted asynchronously and released synchronously.

Top module: `wiper_ctrl`

## Requirements
- R1: `wiper_pos` always lies between 0 and 99.
- R2: `tap_sel` has exactly one bit set, and the index of that bit equals `wiper_pos` (bit 0 is the low end, bit 99 the high end).
- R3: After `nv_rst_n` has blanked the cell, the release of `rst_n` brings the position to 0.
- R4: A high-to-low transition of `step_n` while `sel_n` is low and `dir_up` is 1 increases the position by one.
- R5: A high-to-low transition of `step_n` while `sel_n` is low and `dir_up` is 0 decreases the position by one.
- R6: An upward step at position 99 leaves the position at 99.
- R7: A downward step at position 0 leaves the position at 0.
- R8: Transitions of `step_n` while `sel_n` is high leave the position unchanged.
- R9: A low-to-high transition of `sel_n` while `step_n` is high saves the position. After a later pulse on `rst_n`, the position equals the saved value.
- R10: A low-to-high transition of `sel_n` while `step_n` is low leaves the saved value unchanged.
- R11: A low-to-high transition of `step_n` does not move the position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low; the counter reloads from the saved cell on release |
| nv_rst_n | input | 1 | Blanks the nonvolatile cell to position 0, active low |
| sel_n | input | 1 | Select, active low, asynchronous |
| step_n | input | 1 | Step strobe; the falling edge steps the wiper, asynchronous |
| dir_up | input | 1 | Direction: 1 moves up, 0 moves down |
| wiper_pos | output | 7 | Current wiper position |
| tap_sel | output | 100 | One-hot tap-select vector |

## Verification
Some properties are checked on every clock by assertions:
- the position stays in range;
- the select vector stays one-hot;
- the position is held whenever no step event and no reload occur;
- a step moves the position by exactly one, or holds it at a limit;
- the saved cell changes only on a store event.

Other behaviour depends on how the raw pins are interpreted. The bench scenarios exercise it:
- only falling strobe edges count;
- a deselected strobe is ignored;
- a store depends on the strobe level at the moment of deselect;
- a saved value survives a power-up reset, and a blanked cell recalls 0.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  parameter int unsigned WIPER_TAPS = 100;
  localparam int unsigned WIPER_W = $clog2(WIPER_TAPS);
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE;
      cur_q  <= IDLE;
      prev_q <= IDLE;
    end else begin
      meta_q <= async_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
  parameter int unsigned TAPS = wiper_pkg::WIPER_TAPS,
  localparam int unsigned W = $clog2(TAPS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_ev,
  input  logic         up,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] pos
);
  localparam logic [W-1:0] TOP = W'(TAPS - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (step_ev) begin
      if (up) begin
        if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
      end else begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pos = cnt_q;

  assert_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_ev && !load) |=> $stable(cnt_q));
  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !load && up && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !load && !up && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_sat_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !load && up && cnt_q == TOP) |=> cnt_q == TOP);
  assert_sat_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !load && !up && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/wiper_nv.sv
module wiper_nv #(
  parameter int unsigned W = wiper_pkg::WIPER_W
) (
  input  logic         clk,
  input  logic         blank_n,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] cell_q;
  logic [W-1:0] cell_d;

  always_comb begin
    cell_d = cell_q;
    if (wr) cell_d = wr_val;
  end

  always_ff @(posedge clk or negedge blank_n) begin
    if (!blank_n) cell_q <= '0;
    else          cell_q <= cell_d;
  end

  assign rd_val = cell_q;

  assert_cell_hold_R10: assert property (@(posedge clk) disable iff (!blank_n)
    !wr |=> $stable(cell_q));
endmodule

// File: rtl/wiper_decode.sv
module wiper_decode #(
  parameter int unsigned TAPS = wiper_pkg::WIPER_TAPS,
  localparam int unsigned W = $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    pos,
  output logic [TAPS-1:0] sel
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign sel[i] = (pos == W'(i));
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1);
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int unsigned TAPS = wiper_pkg::WIPER_TAPS,
  localparam int unsigned W = $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nv_rst_n,
  input  logic            sel_n,
  input  logic            step_n,
  input  logic            dir_up,
  output logic [W-1:0]    wiper_pos,
  output logic [TAPS-1:0] tap_sel
);
  // bit order of the synchronized control bundle
  localparam int unsigned B_SEL  = 0;
  localparam int unsigned B_STEP = 1;
  localparam int unsigned B_DIR  = 2;

  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  logic         recall_q;
  logic         recall_d;
  logic [2:0]   raw;
  logic [2:0]   cur;
  logic [2:0]   prev;
  logic         step_ev;
  logic         store_ev;
  logic [W-1:0] pos;
  logic [W-1:0] saved;

  // asynchronous assert, synchronous release of the power-up reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // one reload cycle after the reset is released
  always_comb recall_d = 1'b0;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) recall_q <= 1'b1;
    else            recall_q <= recall_d;
  end

  assign raw[B_SEL]  = sel_n;
  assign raw[B_STEP] = step_n;
  assign raw[B_DIR]  = dir_up;

  wiper_sync #(.W(3), .IDLE(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .async_in(raw), .cur(cur), .prev(prev)
  );

  assign step_ev  = !cur[B_SEL] && prev[B_STEP] && !cur[B_STEP];
  assign store_ev = !prev[B_SEL] && cur[B_SEL] && cur[B_STEP];

  wiper_counter #(.TAPS(TAPS)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .step_ev(step_ev), .up(cur[B_DIR]),
    .load(recall_q), .load_val(saved), .pos(pos)
  );

  wiper_nv #(.W(W)) u_nv (
    .clk(clk), .blank_n(nv_rst_n), .wr(store_ev), .wr_val(pos), .rd_val(saved)
  );

  wiper_decode #(.TAPS(TAPS)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .pos(pos), .sel(tap_sel)
  );

  assign wiper_pos = pos;

  assert_recall_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    recall_q |=> pos == $past(saved));
  assert_rise_no_step_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!prev[B_STEP] && cur[B_STEP] && !recall_q) |=> $stable(pos));
endmodule

// File: tb/wiper_ctrl_tb_top.sv
module wiper_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, nv_rst_n, sel_n, step_n, dir_up;
  logic [6:0]  wiper_pos;
  logic [99:0] tap_sel;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wiper_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .sel_n(sel_n),
    .step_n(step_n), .dir_up(dir_up), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
  );

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pos(int exp, string req);
    logic [99:0] exp_sel;
    exp_sel = '0;
    exp_sel[exp] = 1'b1;
    checks++;
    if (wiper_pos !== 7'(exp) || tap_sel !== exp_sel) begin
      fails++;
      $display("FAIL %s: pos=%0d sel=%h expected pos=%0d sel=%h",
               req, wiper_pos, tap_sel, exp, exp_sel);
    end
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      step_n = 1'b0; idle(5);
      step_n = 1'b1; idle(5);
    end
  endtask

  task automatic power_up;
    rst_n = 1'b0; idle(3);
    rst_n = 1'b1; idle(8);
  endtask

  task automatic t_reset;   // R3 R1 R2
    nv_rst_n = 1'b0; rst_n = 1'b0; idle(3);
    nv_rst_n = 1'b1; rst_n = 1'b1; idle(8);
    check_pos(0, "R3");
  endtask

  task automatic t_up_down; // R4 R5 R11
    sel_n = 1'b0; dir_up = 1'b1; idle(5);
    pulse(5);
    check_pos(5, "R4");
    step_n = 1'b0; idle(5);
    check_pos(6, "R4");
    step_n = 1'b1; idle(5);
    check_pos(6, "R11");
    dir_up = 1'b0; idle(3);
    pulse(2);
    check_pos(4, "R5");
  endtask

  task automatic t_limits;  // R6 R7 R2
    dir_up = 1'b1; idle(3);
    pulse(100);
    check_pos(99, "R6");
    dir_up = 1'b0; idle(3);
    pulse(1);
    check_pos(98, "R5");
    pulse(104);
    check_pos(0, "R7");
  endtask

  task automatic t_deselect; // R8 R9
    dir_up = 1'b1; idle(3);
    pulse(10);
    check_pos(10, "R4");
    sel_n = 1'b1; idle(5);    // store 10, strobe high
    pulse(4);
    check_pos(10, "R8");
    dir_up = 1'b0; idle(3);
    pulse(3);
    check_pos(10, "R8");
  endtask

  task automatic t_store;   // R9 R10
    sel_n = 1'b0; dir_up = 1'b1; idle(5);
    pulse(10);
    step_n = 1'b0; idle(5);   // steps to 21
    sel_n = 1'b1; idle(5);    // deselect with strobe low: no store
    step_n = 1'b1; idle(5);
    check_pos(21, "R8");
    power_up();
    check_pos(10, "R10");
    sel_n = 1'b0; idle(5);
    pulse(95);
    check_pos(99, "R6");
    sel_n = 1'b1; idle(5);    // store 99
    power_up();
    check_pos(99, "R9");
    nv_rst_n = 1'b0; idle(2); nv_rst_n = 1'b1;
    power_up();
    check_pos(0, "R3");
  endtask

  initial begin
    rst_n = 1'b0; nv_rst_n = 1'b0; sel_n = 1'b1; step_n = 1'b1; dir_up = 1'b0;
    t_reset();
    t_up_down();
    t_limits();
    t_deselect();
    t_store();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule